// File: doc/BRIEF.md
# Control-Transfer Resolver

This unit settles the outcome of control-flow instructions for a 32-bit RISC core with two instruction encodings: a full-width mode and a compressed mode. For each instruction it is given the already-decoded transfer class, the result of the condition check, the current PC, a pre-scaled signed offset, the value of a source register and the current encoding mode. From these it works out where execution continues and which side effects apply. The side effects are a link-register write, a change of encoding mode and a software-interrupt request.

The unit does not evaluate conditions, decode instructions or vector exceptions. It reports its result one cycle after an input strobe. The pipeline then uses the flush or advance indication to redirect fetch, the register file takes the link write, and the status logic takes the mode update or the interrupt request.

Top module: `ctl_xfer_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, out_valid, pc_advance, flush, link_we, mode_we and swi_req are 0 and next_pc is 0.
- R2: out_valid is 1 exactly one cycle after in_valid was 1. Whenever out_valid is 0, pc_advance, flush, link_we, mode_we and swi_req are all 0.
- R3: When cond_pass is 0, the instruction has no side effect. pc_advance is 1, flush is 0, link_we, mode_we and swi_req are 0, and next_pc is cur_pc plus 4 in full-width mode (cur_cmode=0) or plus 2 in compressed mode (cur_cmode=1), with wrap-around.
- R4: A passing relative branch (in_class=0) gives next_pc = cur_pc + br_offset modulo 2^32, with flush=1 and pc_advance=0.
- R5: A passing branch-with-link (in_class=1) does the same as R4. It also sets link_we=1, link_idx=14 and link_data = cur_pc with bit 0 cleared.
- R6: A passing register branch-exchange (in_class=2) sets mode_we=1 and mode_cmode = src_val bit 0, where 1 means compressed and 0 means full-width.
- R7: A passing register branch-exchange gives next_pc = src_val with bit 0 cleared, and flush=1.
- R8: A passing software interrupt (in_class=3) sets swi_req=1 and flush=1 and leaves next_pc equal to cur_pc.
- R9: At most one of link_we, mode_we and swi_req is 1 in any cycle. Exactly one of flush and pc_advance is 1 whenever out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| in_class | input | 2 | Transfer class: 0 branch, 1 branch-link, 2 register exchange, 3 software interrupt |
| cond_pass | input | 1 | Condition check result |
| cur_cmode | input | 1 | Current mode, 1 = compressed |
| cur_pc | input | 32 | PC of the instruction |
| br_offset | input | 32 | Sign-extended byte offset |
| src_val | input | 32 | Source register value for register exchange |
| out_valid | output | 1 | Result valid |
| next_pc | output | 32 | PC to continue from |
| pc_advance | output | 1 | Normal sequential advance |
| flush | output | 1 | Pipeline flush for a taken transfer |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 4 | Link register index |
| link_data | output | 32 | Link value |
| mode_we | output | 1 | Mode update enable |
| mode_cmode | output | 1 | New mode, 1 = compressed |
| swi_req | output | 1 | Software-interrupt request |

## Verification
The bench sweeps every class against both condition outcomes and both current modes. Each combination runs with PCs, offsets and source values chosen to sit on edges: zero, the top of the address space where sums wrap, odd values whose bit 0 must be masked, and negative offsets. The failing-condition runs tell the two increment sizes apart and show that no side effect leaks through. Odd against even source values separate the two mode choices from the PC masking. Back-to-back strobes followed by idle cycles show the one-cycle latency and that the outputs are quiet when no strobe is present.

// File: rtl/ctl_xfer_pkg.sv
// Shared types for the control-transfer resolver.
// Assumes the class code is produced by an upstream decoder.
package ctl_xfer_pkg;

    typedef enum logic [1:0] {
        XF_REL      = 2'd0,
        XF_REL_LINK = 2'd1,
        XF_REG_EXCH = 2'd2,
        XF_SWI      = 2'd3
    } xf_class_e;

    typedef struct packed {
        logic advance;
        logic flush;
        logic link;
        logic mode;
        logic swi;
    } xf_act_t;

    localparam xf_act_t XF_ACT_NONE = '{default: 1'b0};

endpackage

// File: rtl/ctl_xfer_decide.sv
// Chooses the action set for one instruction from its class and condition.
// Assumes the class and condition inputs are stable while valid is high.
module ctl_xfer_decide
    import ctl_xfer_pkg::*;
(
    input  logic      valid,
    input  xf_class_e cls,
    input  logic      cond_ok,
    output xf_act_t   act
);

    // Map class and condition to the set of side effects.
    always_comb begin
        act = XF_ACT_NONE;
        if (valid) begin
            if (!cond_ok) begin
                act.advance = 1'b1;
            end else begin
                act.flush = 1'b1;
                unique case (cls)
                    XF_REL:      act.link = 1'b0;
                    XF_REL_LINK: act.link = 1'b1;
                    XF_REG_EXCH: act.mode = 1'b1;
                    XF_SWI:      act.swi  = 1'b1;
                    default:     act = XF_ACT_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/ctl_xfer_target.sv
// Computes the continuation PC, the link value and the requested mode.
// Assumes the offset is already sign-extended and scaled to bytes.
module ctl_xfer_target
    import ctl_xfer_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int FULL_STEP = 4,
    parameter int COMP_STEP = 2
) (
    input  xf_class_e       cls,
    input  logic            cond_ok,
    input  logic            cmode,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] tgt_pc,
    output logic [XLEN-1:0] link_val,
    output logic            new_cmode
);

    localparam logic [XLEN-1:0] LSB_CLR = {{(XLEN-1){1'b1}}, 1'b0};

    logic [XLEN-1:0] step;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_pc;
    logic [XLEN-1:0] reg_pc;

    // Pick the sequential step; collapse the mux when both modes share a size.
    generate
        if (FULL_STEP == COMP_STEP) begin : g_step_fixed
            assign step = XLEN'(FULL_STEP);
        end else begin : g_step_mux
            assign step = cmode ? XLEN'(COMP_STEP) : XLEN'(FULL_STEP);
        end
    endgenerate

    // Candidate addresses, all modulo 2^XLEN.
    always_comb begin
        seq_pc = pc + step;
        rel_pc = pc + offset;
        reg_pc = src & LSB_CLR;
    end

    // Select the continuation PC for this class.
    always_comb begin
        if (!cond_ok) begin
            tgt_pc = seq_pc;
        end else begin
            unique case (cls)
                XF_REL, XF_REL_LINK: tgt_pc = rel_pc;
                XF_REG_EXCH:         tgt_pc = reg_pc;
                default:             tgt_pc = pc;
            endcase
        end
    end

    // Link value and new mode come straight from their sources.
    always_comb begin
        link_val  = pc & LSB_CLR;
        new_cmode = src[0];
    end

endmodule

// File: rtl/ctl_xfer_unit.sv
// Control-transfer resolver: registers the action set and target one cycle
// after an input strobe. Assumes decode and condition evaluation upstream.
module ctl_xfer_unit
    import ctl_xfer_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int RIDX_W    = 4,
    parameter int LINK_IDX  = 14,
    parameter int FULL_STEP = 4,
    parameter int COMP_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_class,
    input  logic              cond_pass,
    input  logic              cur_cmode,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   br_offset,
    input  logic [XLEN-1:0]   src_val,
    output logic              out_valid,
    output logic [XLEN-1:0]   next_pc,
    output logic              pc_advance,
    output logic              flush,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_data,
    output logic              mode_we,
    output logic              mode_cmode,
    output logic              swi_req
);

    localparam logic [RIDX_W-1:0] LINK_SEL = RIDX_W'(LINK_IDX);

    xf_class_e       cls;
    xf_act_t         act;
    xf_act_t         act_q;
    logic [XLEN-1:0] tgt_pc;
    logic [XLEN-1:0] link_val;
    logic            new_cmode;

    assign cls = xf_class_e'(in_class);

    ctl_xfer_decide i_decide (
        .valid   (in_valid),
        .cls     (cls),
        .cond_ok (cond_pass),
        .act     (act)
    );

    ctl_xfer_target #(
        .XLEN      (XLEN),
        .FULL_STEP (FULL_STEP),
        .COMP_STEP (COMP_STEP)
    ) i_target (
        .cls       (cls),
        .cond_ok   (cond_pass),
        .cmode     (cur_cmode),
        .pc        (cur_pc),
        .offset    (br_offset),
        .src       (src_val),
        .tgt_pc    (tgt_pc),
        .link_val  (link_val),
        .new_cmode (new_cmode)
    );

    // Strobes: cleared in reset, reloaded every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            act_q     <= XF_ACT_NONE;
        end else begin
            out_valid <= in_valid;
            act_q     <= act;
        end
    end

    // Data: cleared in reset, loaded only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc    <= '0;
            link_data  <= '0;
            mode_cmode <= 1'b0;
        end else if (in_valid) begin
            next_pc    <= tgt_pc;
            link_data  <= link_val;
            mode_cmode <= new_cmode;
        end
    end

    // Expose the registered action set.
    always_comb begin
        pc_advance = act_q.advance;
        flush      = act_q.flush;
        link_we    = act_q.link;
        mode_we    = act_q.mode;
        swi_req    = act_q.swi;
        link_idx   = LINK_SEL;
    end

endmodule

// File: rtl/ctl_xfer_chk.sv
// Protocol checker for ctl_xfer_unit, attached by bind.
// Assumes a synchronous active-low reset.
module ctl_xfer_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      in_class,
    input logic            cond_pass,
    input logic [XLEN-1:0] cur_pc,
    input logic            out_valid,
    input logic [XLEN-1:0] next_pc,
    input logic            pc_advance,
    input logic            flush,
    input logic            link_we,
    input logic [XLEN-1:0] link_data,
    input logic            mode_we,
    input logic            swi_req
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(pc_advance || flush || link_we || mode_we || swi_req));  // R2
    AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({link_we, mode_we, swi_req}) <= 1);  // R9
    AST_FLUSH_OR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flush != pc_advance));  // R9
    AST_FAIL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_pass) |=> (pc_advance && !link_we && !mode_we && !swi_req));  // R3
    AST_LINK_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data[0] == 1'b0));  // R5
    AST_EXCH_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |-> (next_pc[0] == 1'b0));  // R7
    AST_SWI_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_pass && in_class == 2'd3) |=> (swi_req && next_pc == $past(cur_pc)));  // R8

endmodule

bind ctl_xfer_unit ctl_xfer_chk #(.XLEN(XLEN)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_class   (in_class),
    .cond_pass  (cond_pass),
    .cur_pc     (cur_pc),
    .out_valid  (out_valid),
    .next_pc    (next_pc),
    .pc_advance (pc_advance),
    .flush      (flush),
    .link_we    (link_we),
    .link_data  (link_data),
    .mode_we    (mode_we),
    .swi_req    (swi_req)
);

// File: tb/test_ctl_xfer_unit.sv
module test_ctl_xfer_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_class = 2'd0;
    logic        cond_pass = 1'b0;
    logic        cur_cmode = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] br_offset = '0;
    logic [31:0] src_val = '0;
    logic        out_valid;
    logic [31:0] next_pc;
    logic        pc_advance;
    logic        flush;
    logic        link_we;
    logic [3:0]  link_idx;
    logic [31:0] link_data;
    logic        mode_we;
    logic        mode_cmode;
    logic        swi_req;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ctl_xfer_unit i_ctl_xfer_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .cond_pass(cond_pass), .cur_cmode(cur_cmode), .cur_pc(cur_pc),
        .br_offset(br_offset), .src_val(src_val), .out_valid(out_valid),
        .next_pc(next_pc), .pc_advance(pc_advance), .flush(flush),
        .link_we(link_we), .link_idx(link_idx), .link_data(link_data),
        .mode_we(mode_we), .mode_cmode(mode_cmode), .swi_req(swi_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pick_pc(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0100;
            2: return 32'hFFFF_FFFC;
            3: return 32'h8000_0001;
            4: return 32'h1234_5679;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] pick_off(input int k);
        case (k)
            0: return 32'h0000_0004;
            1: return 32'hFFFF_FFF8;
            2: return 32'h0000_0008;
            3: return 32'h7FFF_FFF0;
            4: return 32'hFFFF_FFFC;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [31:0] pick_src(input int k);
        case (k)
            0: return 32'h0000_0201;
            1: return 32'h0000_0300;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0001;
            4: return 32'h8000_0000;
            default: return 32'h1234_5678;
        endcase
    endfunction

    // Drive one instruction at a falling edge; check its result one cycle later.
    task automatic run_one(input int cls, input bit cp, input bit cm, input int k);
        logic [31:0] e_pc;
        bit e_adv, e_fl, e_lk, e_md, e_sw;
        in_valid  = 1'b1;
        in_class  = 2'(cls);
        cond_pass = cp;
        cur_cmode = cm;
        cur_pc    = pick_pc(k);
        br_offset = pick_off(k);
        src_val   = pick_src(k);
        e_adv = !cp;
        e_fl = cp;
        e_lk = cp && cls == 1;
        e_md = cp && cls == 2;
        e_sw = cp && cls == 3;
        if (!cp) e_pc = cur_pc + (cm ? 32'd2 : 32'd4);
        else if (cls <= 1) e_pc = cur_pc + br_offset;
        else if (cls == 2) e_pc = {src_val[31:1], 1'b0};
        else e_pc = cur_pc;
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 out_valid", 32'(out_valid), 32'd1);
        if (!cp) begin
            chk(next_pc == e_pc, "R3 next_pc", next_pc, e_pc);
            chk(pc_advance && !flush && !link_we && !mode_we && !swi_req, "R3 strobes",
                {27'd0, pc_advance, flush, link_we, mode_we, swi_req}, 32'b10000);
        end else begin
            case (cls)
                0: chk(next_pc == e_pc, "R4 next_pc", next_pc, e_pc);
                1: chk(next_pc == e_pc, "R5 next_pc", next_pc, e_pc);
                2: chk(next_pc == e_pc, "R7 next_pc", next_pc, e_pc);
                default: chk(next_pc == e_pc, "R8 next_pc", next_pc, e_pc);
            endcase
            chk(flush == e_fl && pc_advance == e_adv, "R4 flush/advance",
                {30'd0, flush, pc_advance}, {30'd0, e_fl, e_adv});
            chk(link_we == e_lk, "R5 link_we", 32'(link_we), 32'(e_lk));
            chk(mode_we == e_md, "R6 mode_we", 32'(mode_we), 32'(e_md));
            chk(swi_req == e_sw, "R8 swi_req", 32'(swi_req), 32'(e_sw));
            if (e_lk) begin
                chk(link_data == {cur_pc[31:1], 1'b0}, "R5 link_data", link_data, {cur_pc[31:1], 1'b0});
                chk(link_idx == 4'd14, "R5 link_idx", 32'(link_idx), 32'd14);
            end
            if (e_md) chk(mode_cmode == src_val[0], "R6 mode_cmode", 32'(mode_cmode), 32'(src_val[0]));
        end
        chk($countones({link_we, mode_we, swi_req}) <= 1, "R9 one effect",
            {29'd0, link_we, mode_we, swi_req}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !pc_advance && !flush && !link_we && !mode_we && !swi_req,
            "R1 strobes in reset", {26'd0, out_valid, pc_advance, flush, link_we, mode_we, swi_req}, 32'd0);
        chk(next_pc == 32'd0, "R1 next_pc in reset", next_pc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !flush && !pc_advance, "R1 after reset",
            {29'd0, out_valid, flush, pc_advance}, 32'd0);
        for (int cls = 0; cls < 4; cls++)
            for (int cp = 0; cp < 2; cp++)
                for (int cm = 0; cm < 2; cm++)
                    for (int k = 0; k < 6; k++)
                        run_one(cls, cp[0], cm[0], k);
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R2 no strobe no valid", 32'(out_valid), 32'd0);
        chk(!pc_advance && !flush && !link_we && !mode_we && !swi_req, "R2 idle quiet",
            {27'd0, pc_advance, flush, link_we, mode_we, swi_req}, 32'd0);
        run_one(2, 1'b1, 1'b0, 3);
        in_valid = 1'b0;
        @(negedge clk);
        chk(!mode_we && !out_valid, "R2 single pulse", {30'd0, mode_we, out_valid}, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule